// File: doc/BRIEF.md
# Port-Numbered Parallel I/O Interface

This block attaches one byte-wide output port and one byte-wide input port to a processor bus that keeps I/O apart from memory. I/O cycles are marked by a space-select line held high. Each port answers to its own 8-bit port number, so it can sit anywhere in the 256-entry I/O space. The block reads the demultiplexed low address, the space-select line and the active-low read and write strobes. It takes no notice of memory cycles.

A write to the output port lasts only a few clocks. The block holds that byte for the external pins. While the qualified write strobe is active, it stages the bus byte on every clock. On the first clock edge at which the qualification is no longer present, it moves the staged byte into the pin register, which then keeps the value until the next write. For reads, the external input byte goes to the shared data bus through a drive enable. A top-level tri-state buffer uses that enable, and it is active only while the input port is being read.

The two port numbers are parameters and may be equal. A write and a read to the same number never overlap as strobes, but the commit of a finished write and a new read can fall in the same cycle.

Top module: `pio_port`

## Requirements
- R1: While reset is active, and after it is released, `port_out` is 8'h00 and `rd_oe` is 0.
- R2: A write cycle has `io_sel`=1, `wr_n`=0 and `addr`=OUT_PORT. On the first rising clock edge at which that condition no longer holds, `port_out` takes the `wdata` value sampled at the last edge where it did hold.
- R3: `port_out` does not change while the qualified write strobe is still active.
- R4: A write strobe with `io_sel`=0 (a memory cycle) leaves `port_out` unchanged.
- R5: A write strobe with `io_sel`=1 and an address other than OUT_PORT leaves `port_out` unchanged.
- R6: After a write commits, `port_out` keeps its value when `wdata` and the strobes change.
- R7: When `io_sel`=1, `rd_n`=0 and `addr`=IN_PORT hold together, `rd_oe` is 1 and `rdata` equals `pins_in` in the same cycle, with no clock delay.
- R8: `rd_oe` is 0 whenever `io_sel`=0, `rd_n`=1 or `addr`≠IN_PORT.
- R9: `rdata` is 8'h00 whenever `rd_oe` is 0.
- R10: When OUT_PORT equals IN_PORT, a write commit and a read of the input port in the same cycle both complete correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Latched low address (port number) |
| io_sel | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| wdata | input | 8 | Data bus byte driven by the processor |
| pins_in | input | 8 | External input port pins |
| rdata | output | 8 | Byte to drive on the data bus (0 when not enabled) |
| rd_oe | output | 1 | Data bus drive enable for the tri-state buffer |
| port_out | output | 8 | External output port pins |

## Verification
Two functions can fall in the same cycle: the delayed commit of the output write, and a combinational read of the input port. With both port numbers left equal at their defaults, the bench raises the write strobe and drops the read strobe at the same address in one clock. It then checks that the drive enable and the input byte appear at once and that the pin register takes the written byte at the following edge. Each function is judged against its expected value, so the bench can tell whether one of them blocked or corrupted the other.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 8;

  // true when a qualified I/O access targets the given port
  function automatic logic io_hit(input logic [AW-1:0] a,
                                  input logic [AW-1:0] port,
                                  input logic io,
                                  input logic strobe_n);
    return io && !strobe_n && (a == port);
  endfunction
endpackage

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
#(
  parameter logic [AW-1:0] OUT_PORT = 8'h40,
  parameter logic [AW-1:0] IN_PORT  = 8'h40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          io_sel,
  input  logic          rd_n,
  input  logic          wr_n,
  output logic          wr_hit,
  output logic          rd_hit
);
  assign wr_hit = io_hit(addr, OUT_PORT, io_sel, wr_n);
  assign rd_hit = io_hit(addr, IN_PORT, io_sel, rd_n);

  a_r4_mem_cycle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !io_sel |-> (!wr_hit && !rd_hit));
  a_r8_read_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (!rd_n && io_sel && addr == IN_PORT));
endmodule

// File: rtl/pio_out_reg.sv
module pio_out_reg
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [DW-1:0] wdata,
  output logic          commit,
  output logic [DW-1:0] port_out
);
  logic          hit_q;
  logic [DW-1:0] stage;

  // qualification present last edge, gone now: write has ended
  assign commit = hit_q && !wr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q    <= 1'b0;
      stage    <= '0;
      port_out <= '0;
    end else begin
      hit_q <= wr_hit;
      if (wr_hit) stage <= wdata;
      if (commit) port_out <= stage;
    end
  end

  a_r2_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (port_out == $past(stage)));
  a_r3_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(port_out));
endmodule

// File: rtl/pio_in_drv.sv
module pio_in_drv
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_hit,
  input  logic [DW-1:0] pins_in,
  output logic [DW-1:0] rdata,
  output logic          rd_oe
);
  assign rd_oe = rd_hit;
  assign rdata = rd_hit ? pins_in : '0;

  a_r7_drives_pins: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> (rdata == pins_in));
  a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rdata == '0));
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter logic [AW-1:0] OUT_PORT = 8'h40,
  parameter logic [AW-1:0] IN_PORT  = 8'h40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          io_sel,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pins_in,
  output logic [DW-1:0] rdata,
  output logic          rd_oe,
  output logic [DW-1:0] port_out
);
  logic wr_hit, rd_hit, commit;

  pio_decode #(.OUT_PORT(OUT_PORT), .IN_PORT(IN_PORT)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(addr), .io_sel(io_sel),
    .rd_n(rd_n), .wr_n(wr_n), .wr_hit(wr_hit), .rd_hit(rd_hit));

  pio_out_reg u_out (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(wdata),
    .commit(commit), .port_out(port_out));

  pio_in_drv u_in (
    .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .pins_in(pins_in),
    .rdata(rdata), .rd_oe(rd_oe));

  a_r10_no_strobe_overlap_drive: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> !wr_hit);
endmodule

// File: tb/pio_port_test.sv
`timescale 1ns/1ps
module pio_port_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] addr = 0, wdata = 0, pins_in = 0;
  logic       io_sel = 0, rd_n = 1, wr_n = 1;
  logic [7:0] rdata, port_out;
  logic       rd_oe;
  int checks = 0, fails = 0;
  logic [7:0] held;
  localparam logic [7:0] PORT = 8'h40;

  always #5 clk = ~clk;

  pio_port uut (.clk(clk), .rst_n(rst_n), .addr(addr), .io_sel(io_sel),
    .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .pins_in(pins_in),
    .rdata(rdata), .rd_oe(rd_oe), .port_out(port_out));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    io_sel = 0; rd_n = 1; wr_n = 1; addr = 0;
  endtask

  // strobe for two clocks with data d, then release; returns after commit edge
  task automatic do_write(input logic [7:0] a, input logic io, input logic [7:0] d,
                          input logic [7:0] exp_after, input string req);
    @(negedge clk);
    addr = a; io_sel = io; wdata = d; wr_n = 0;
    @(negedge clk);
    chk("R3", port_out, held);
    @(negedge clk);
    chk("R3", port_out, held);
    wr_n = 1;
    @(negedge clk);
    chk(req, port_out, exp_after);
    held = port_out;
  endtask

  task automatic t_reset();
    #1; chk("R1", port_out, 8'h00); chk("R1", {7'b0, rd_oe}, 8'h00);
    @(negedge clk); rst_n = 1;
    @(negedge clk); chk("R1", port_out, 8'h00); chk("R1", {7'b0, rd_oe}, 8'h00);
    held = 8'h00;
  endtask

  task automatic t_write();
    do_write(PORT, 1, 8'h5A, 8'h5A, "R2");
    do_write(PORT, 1, 8'hC3, 8'hC3, "R2");
  endtask

  task automatic t_ignored_writes();
    do_write(PORT, 0, 8'h11, held, "R4");
    do_write(8'h41, 1, 8'h22, held, "R5");
    do_write(8'hC0, 1, 8'h33, held, "R5");
  endtask

  task automatic t_hold();
    @(negedge clk); wdata = 8'hFF; io_sel = 1; addr = PORT; rd_n = 0;
    repeat (5) @(negedge clk);
    chk("R6", port_out, held);
    idle();
    repeat (3) @(negedge clk);
    chk("R6", port_out, held);
  endtask

  task automatic t_read();
    @(negedge clk); pins_in = 8'h96; addr = PORT; io_sel = 1; rd_n = 0;
    #1; chk("R7", {7'b0, rd_oe}, 8'h01); chk("R7", rdata, 8'h96);
    pins_in = 8'h69;
    #1; chk("R7", rdata, 8'h69);
    @(negedge clk); io_sel = 0;
    #1; chk("R8", {7'b0, rd_oe}, 8'h00); chk("R9", rdata, 8'h00);
    @(negedge clk); io_sel = 1; addr = 8'h41;
    #1; chk("R8", {7'b0, rd_oe}, 8'h00); chk("R9", rdata, 8'h00);
    @(negedge clk); addr = PORT; rd_n = 1;
    #1; chk("R8", {7'b0, rd_oe}, 8'h00); chk("R9", rdata, 8'h00);
    idle();
  endtask

  task automatic t_same_cycle();
    @(negedge clk); addr = PORT; io_sel = 1; wdata = 8'hA5; wr_n = 0;
    @(negedge clk);
    @(negedge clk); wr_n = 1; rd_n = 0; pins_in = 8'h3C;
    #1; chk("R10", {7'b0, rd_oe}, 8'h01); chk("R10", rdata, 8'h3C);
    chk("R10", port_out, held);
    @(negedge clk);
    chk("R10", port_out, 8'hA5); chk("R10", rdata, 8'h3C);
    held = 8'hA5;
    idle();
  endtask

  initial begin
    fork
      begin
        t_reset(); t_write(); t_ignored_writes(); t_hold();
        t_read(); t_same_cycle();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule